// File: doc/BRIEF.md
# Interleaved IQ Ping-Pong Capture

This block takes a stereo serial audio stream (I2S framing, block acting as slave) in which the left slot carries the in-phase sample and the right slot carries the quadrature sample. It rebuilds 24-bit words from the serial bits and stores each completed I/Q pair into one of two alternating buffers in an on-chip memory. Within a buffer, the I word of pair p sits at address 2p and the Q word at 2p+1. A consumer can therefore step through a pair with a single address increment.

When a buffer has received its full count of pairs, the block raises a ready flag for that buffer and switches writing to the other one. The consumer reads the ready buffer through a synchronous read port that sign-extends each word to 32 bits. It returns the buffer by pulsing the matching acknowledge bit. The serial clock, word select and data are asynchronous to the system clock and pass through two-flop synchronisers. Bits are taken on detected rising edges of the serial clock.

Top module: `iq_pingpong_capture`

## Requirements
- R1: Bits are taken MSB first on rising serial-clock edges. The bit at the first rising edge after a word-select change is skipped, and the next 24 bits form the word. Later bits of the slot are ignored. Nothing is captured before the first word-select change seen after reset.
- R2: A word received with word select low is I and is written at buffer address 2p. A word received with word select high is Q and is written at 2p+1, where p is the pair index within the buffer.
- R3: A pair is committed, and the pair index advanced, only when a Q word follows an I word. A Q word with no preceding I word is neither stored nor counted.
- R4: Writing starts in buffer 0 after reset. After PAIRS committed pairs, ready bit k (rdy[k], for buffer k) is set and writing moves to the other buffer. Buffers alternate 0, 1, 0, and so on.
- R5: A pulse on ack[k] clears rdy[k]. At most one ready bit is ever set.
- R6: If a buffer completes while the other buffer's ready bit is still set, overrun is set and stays set until reset. The older ready bit is withdrawn, and only the newly completed buffer is flagged.
- R7: rd_data shows the word at {rd_buf, rd_addr} one clock after those inputs are applied. It is sign-extended from 24 to 32 bits, so 0x800000 reads as 0xFF800000.
- R8: After reset, rdy is 0 and overrun is 0.
- R9: The writer never writes into a buffer whose ready bit is set. The contents of a ready buffer stay intact while the other buffer fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial bit clock (asynchronous) |
| ws | input | 1 | Word select: low = I slot, high = Q slot |
| sd | input | 1 | Serial data, MSB first |
| rd_buf | input | 1 | Buffer selected for reading |
| rd_addr | input | ADDR_W | Word address within the buffer (I even, Q odd) |
| rd_data | output | RD_W | Sign-extended word, one cycle after the address |
| rdy | output | 2 | Per-buffer ready flags |
| ack | input | 2 | Per-buffer acknowledge pulses |
| overrun | output | 1 | Sticky overrun indicator |

## Verification
The capture path is exercised with a table of eight pairs:
- positive words, negative words and the two extreme codes, which separate sign extension from plain zero-padding;
- alternating bit patterns, which expose bit-order or off-by-one slot alignment.

The stream also begins with a long run of bits before any word-select change, followed by a lone Q slot. Any premature lock or uncommitted pair would shift every later address in buffer 0.

A second pass leaves buffer 0 unacknowledged while buffer 1 fills. This tells apart a design that protects the ready buffer and flags overrun from one that overwrites or double-flags.

// File: rtl/iq_cap_pkg.sv
package iq_cap_pkg;
  typedef enum logic {SLOT_I = 1'b0, SLOT_Q = 1'b1} slot_e;
endpackage

// File: rtl/iq_i2s_rx.sv
module iq_i2s_rx #(
  parameter int SAMPLE_W = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sck_a,
  input  logic                  ws_a,
  input  logic                  sd_a,
  output logic                  word_vld,
  output iq_cap_pkg::slot_e     word_slot,
  output logic [SAMPLE_W-1:0]   word_data
);
  localparam int CNT_W = $clog2(SAMPLE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_W - 1);

  logic [2:0] sck_s;
  logic [1:0] ws_s, sd_s;
  logic       rise;

  logic                ws_prev_q, ws_prev_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic [SAMPLE_W-1:0] sh_q, sh_n;
  logic                vld_q, vld_n;

  // synchronisers, third sck stage for edge detect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0;
      ws_s  <= '0;
      sd_s  <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sck_a};
      ws_s  <= {ws_s[0], ws_a};
      sd_s  <= {sd_s[0], sd_a};
    end
  end

  assign rise = sck_s[1] & ~sck_s[2];

  always_comb begin
    ws_prev_n = ws_prev_q;
    cnt_n     = cnt_q;
    sh_n      = sh_q;
    vld_n     = 1'b0;
    if (rise) begin
      ws_prev_n = ws_s[1];
      if (ws_s[1] != ws_prev_q) begin
        cnt_n = '0;                       // delay bit after slot change
      end else if (cnt_q != CNT_FULL) begin
        sh_n  = {sh_q[SAMPLE_W-2:0], sd_s[1]};
        cnt_n = cnt_q + 1'b1;
        vld_n = (cnt_q == CNT_LAST);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_prev_q <= 1'b0;
      cnt_q     <= CNT_FULL;              // idle until first slot change
      sh_q      <= '0;
      vld_q     <= 1'b0;
    end else begin
      ws_prev_q <= ws_prev_n;
      cnt_q     <= cnt_n;
      sh_q      <= sh_n;
      vld_q     <= vld_n;
    end
  end

  assign word_vld  = vld_q;
  assign word_slot = iq_cap_pkg::slot_e'(ws_prev_q);
  assign word_data = sh_q;
endmodule

// File: rtl/iq_buf_ctrl.sv
module iq_buf_ctrl #(
  parameter int SAMPLE_W = 24,
  parameter int PAIRS    = 1024,
  localparam int PAIR_W  = $clog2(PAIRS),
  localparam int MEM_AW  = PAIR_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_vld,
  input  iq_cap_pkg::slot_e   word_slot,
  input  logic [SAMPLE_W-1:0] word_data,
  input  logic [1:0]          ack,
  output logic                wr_en,
  output logic [MEM_AW-1:0]   wr_addr,
  output logic [SAMPLE_W-1:0] wr_data,
  output logic                wr_buf,
  output logic                buf_done,
  output logic [1:0]          rdy,
  output logic                overrun
);
  localparam logic [PAIR_W-1:0] PAIR_LAST = PAIR_W'(PAIRS - 1);

  logic              buf_q, buf_n;
  logic [PAIR_W-1:0] pair_q, pair_n;
  logic              igot_q, igot_n;
  logic [1:0]        rdy_q, rdy_n;
  logic              ovr_q, ovr_n;
  logic              is_q;

  assign is_q = (word_slot == iq_cap_pkg::SLOT_Q);

  always_comb begin
    buf_n    = buf_q;
    pair_n   = pair_q;
    igot_n   = igot_q;
    ovr_n    = ovr_q;
    wr_en    = 1'b0;
    buf_done = 1'b0;
    if (word_vld) begin
      if (!is_q) begin
        wr_en  = 1'b1;
        igot_n = 1'b1;
      end else if (igot_q) begin
        wr_en  = 1'b1;
        igot_n = 1'b0;
        if (pair_q == PAIR_LAST) begin
          buf_done = 1'b1;
          pair_n   = '0;
          buf_n    = ~buf_q;
        end else begin
          pair_n = pair_q + 1'b1;
        end
      end
    end
    rdy_n = rdy_q & ~ack;
    if (buf_done) begin
      if (rdy_n[~buf_q]) begin
        ovr_n         = 1'b1;
        rdy_n[~buf_q] = 1'b0;               // oldest buffer is reclaimed
      end
      rdy_n[buf_q] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= 1'b0;
      pair_q <= '0;
      igot_q <= 1'b0;
      rdy_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      buf_q  <= buf_n;
      pair_q <= pair_n;
      igot_q <= igot_n;
      rdy_q  <= rdy_n;
      ovr_q  <= ovr_n;
    end
  end

  assign wr_addr = {buf_q, pair_q, is_q};
  assign wr_data = word_data;
  assign wr_buf  = buf_q;
  assign rdy     = rdy_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/iq_sample_ram.sv
module iq_sample_ram #(
  parameter int SAMPLE_W = 24,
  parameter int AW       = 12,
  parameter int RD_W     = 32,
  localparam int DEPTH   = 1 << AW,
  localparam int EXT_W   = RD_W - SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [SAMPLE_W-1:0] wr_data,
  input  logic [AW-1:0]       rd_addr,
  output logic [RD_W-1:0]     rd_data
);
  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [SAMPLE_W-1:0] word;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign word = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= {{EXT_W{word[SAMPLE_W-1]}}, word};
  end
endmodule

// File: rtl/iq_pingpong_capture.sv
module iq_pingpong_capture #(
  parameter int SAMPLE_W = 24,
  parameter int PAIRS    = 1024,
  parameter int RD_W     = 32,
  localparam int ADDR_W  = $clog2(PAIRS) + 1,
  localparam int MEM_AW  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              ws,
  input  logic              sd,
  input  logic              rd_buf,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [RD_W-1:0]   rd_data,
  output logic [1:0]        rdy,
  input  logic [1:0]        ack,
  output logic              overrun
);
  logic [1:0]          rst_sync;
  logic                rst_i_n;
  logic                word_vld;
  iq_cap_pkg::slot_e   word_slot;
  logic [SAMPLE_W-1:0] word_data;
  logic                wr_en;
  logic [MEM_AW-1:0]   wr_addr;
  logic [SAMPLE_W-1:0] wr_data;
  logic                wr_buf;
  logic                buf_done;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  iq_i2s_rx #(.SAMPLE_W(SAMPLE_W)) u_rx (
    .clk(clk), .rst_n(rst_i_n),
    .sck_a(sck), .ws_a(ws), .sd_a(sd),
    .word_vld(word_vld), .word_slot(word_slot), .word_data(word_data)
  );

  iq_buf_ctrl #(.SAMPLE_W(SAMPLE_W), .PAIRS(PAIRS)) u_ctrl (
    .clk(clk), .rst_n(rst_i_n),
    .word_vld(word_vld), .word_slot(word_slot), .word_data(word_data),
    .ack(ack),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_buf(wr_buf), .buf_done(buf_done),
    .rdy(rdy), .overrun(overrun)
  );

  iq_sample_ram #(.SAMPLE_W(SAMPLE_W), .AW(MEM_AW), .RD_W(RD_W)) u_ram (
    .clk(clk), .rst_n(rst_i_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr({rd_buf, rd_addr}), .rd_data(rd_data)
  );
endmodule

// File: rtl/iq_cap_chk.sv
module iq_cap_chk #(
  parameter int SAMPLE_W = 24,
  parameter int RD_W     = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      rdy,
  input logic [1:0]      ack,
  input logic            overrun,
  input logic [RD_W-1:0] rd_data,
  input logic            wr_en,
  input logic            wr_buf,
  input logic            buf_done
);
  logic [RD_W-SAMPLE_W:0] top_bits;
  assign top_bits = rd_data[RD_W-1:SAMPLE_W-1];

  // R5: never two ready flags
  a_r5_rdy_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rdy));

  // R5: an acknowledge clears its flag unless a completion sets it again
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[0] && !buf_done) |=> !rdy[0]);

  // R6: overrun is sticky
  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R4: a flag rises only after a buffer completion
  a_r4_rdy_from_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy[1]) |-> $past(buf_done));

  // R9: no write into a buffer that is flagged ready
  a_r9_no_write_ready: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !rdy[wr_buf]);

  // R7: upper bits of the read word are a sign extension
  a_r7_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    ((&top_bits) || !(|top_bits)));
endmodule

bind iq_pingpong_capture iq_cap_chk #(.SAMPLE_W(SAMPLE_W), .RD_W(RD_W)) u_chk (
  .clk(clk), .rst_n(rst_i_n), .rdy(rdy), .ack(ack), .overrun(overrun),
  .rd_data(rd_data), .wr_en(wr_en), .wr_buf(wr_buf), .buf_done(buf_done)
);

// File: tb/tb_iq_pingpong_capture.sv
module tb_iq_pingpong_capture;
  localparam int CLK_PERIOD = 10;
  localparam int PAIRS      = 4;
  localparam int ADDR_W     = 3;
  localparam int HALF_BIT   = 4;

  // stimulus/expected table: I,Q words of eight pairs (two buffers)
  localparam logic [23:0] VEC [16] = '{
    24'h000001, 24'hFFFFFF, 24'h7FFFFF, 24'h800000,
    24'hA5A5A5, 24'h5A5A5A, 24'h123456, 24'hFEDCBA,
    24'h00FF00, 24'hFF00FF, 24'h400000, 24'hC00001,
    24'h0F0F0F, 24'hF0F0F0, 24'h000000, 24'h876543
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic rd_buf = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [1:0] rdy;
  logic [1:0] ack = 2'b00;
  logic overrun;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iq_pingpong_capture #(.PAIRS(PAIRS)) dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ws(ws), .sd(sd),
    .rd_buf(rd_buf), .rd_addr(rd_addr), .rd_data(rd_data),
    .rdy(rdy), .ack(ack), .overrun(overrun)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bit_t(input logic w, input logic d);
    @(negedge clk); ws = w; sd = d;
    repeat (HALF_BIT) @(negedge clk);
    sck = 1'b1;
    repeat (HALF_BIT) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic slot(input logic w, input logic [23:0] v);
    for (int t = 0; t < 32; t++)
      bit_t(w, (t >= 1 && t <= 24) ? v[24-t] : 1'b0);
  endtask

  task automatic read_chk(input logic b, input int a, input logic [23:0] v, input string tag);
    logic [31:0] exp;
    exp = {{8{v[23]}}, v};
    @(negedge clk); rd_buf = b; rd_addr = ADDR_W'(a);
    @(negedge clk);
    chk(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic wait_rdy(input logic [1:0] exp, input string tag);
    for (int i = 0; i < 300 && rdy != exp; i++) @(negedge clk);
    chk(rdy == exp, tag, {30'd0, rdy}, {30'd0, exp});
  endtask

  task automatic do_ack(input logic [1:0] a);
    @(negedge clk); ack = a;
    @(negedge clk); ack = 2'b00;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(rdy == 2'b00, "R8 rdy after reset", {30'd0, rdy}, 32'd0);
    chk(overrun == 1'b0, "R8 overrun after reset", {31'd0, overrun}, 32'd0);

    // R1: bits before any word-select change are ignored
    for (int i = 0; i < 40; i++) bit_t(1'b0, 1'b1);
    // R3: lone Q slot with no I before it is dropped
    slot(1'b1, 24'h123456);

    // table walk: two buffers, filled and read back in turn
    for (int b = 0; b < 2; b++) begin
      for (int p = 0; p < PAIRS; p++) begin
        slot(1'b0, VEC[2*(PAIRS*b+p)]);
        slot(1'b1, VEC[2*(PAIRS*b+p)+1]);
      end
      wait_rdy(2'(1 << b), "R4 buffer ready flag");
      chk(overrun == 1'b0, "R6 no overrun when acknowledged", {31'd0, overrun}, 32'd0);
      for (int a = 0; a < 2*PAIRS; a++)
        read_chk(b[0], a, VEC[2*PAIRS*b+a], "R1 R2 R3 R7 stored word");
      do_ack(2'(1 << b));
      chk(rdy == 2'b00, "R5 ack clears ready", {30'd0, rdy}, 32'd0);
    end

    // overrun: fill buffer 0, leave it unacknowledged, fill buffer 1
    for (int p = 0; p < PAIRS; p++) begin
      slot(1'b0, 24'h0A0000 + 24'(p));
      slot(1'b1, 24'hF00000 + 24'(p));
    end
    wait_rdy(2'b01, "R4 buffer 0 ready again");
    for (int p = 0; p < PAIRS; p++) begin
      slot(1'b0, 24'h0B0000 + 24'(p));
      slot(1'b1, 24'hE00000 + 24'(p));
      if (p == 1) begin
        // R9: ready buffer 0 untouched while buffer 1 fills
        read_chk(1'b0, 0, 24'h0A0000, "R9 ready buffer intact I");
        read_chk(1'b0, 3, 24'hF00001, "R9 ready buffer intact Q");
      end
    end
    wait_rdy(2'b10, "R6 only newest buffer flagged");
    chk(overrun == 1'b1, "R6 overrun set", {31'd0, overrun}, 32'd1);
    read_chk(1'b1, 2*PAIRS-1, 24'hE00000 + 24'(PAIRS-1), "R2 R7 last Q of buffer 1");
    do_ack(2'b10);
    chk(rdy == 2'b00, "R5 ack buffer 1", {30'd0, rdy}, 32'd0);
    chk(overrun == 1'b1, "R6 overrun sticky", {31'd0, overrun}, 32'd1);

    finish_run();
  end
endmodule